// File: doc/BRIEF.md
# Segment Valid/Dirty Metastate Tracker

This block keeps the valid and dirty state of every L1 line in its own small structure, apart from the data array, and groups the lines by memory segment. Each line records the segment it was filled for. Software works on one segment at a time with two commands. A checkout throws away the cached copy of a segment. A checkin pushes every modified line of a segment back to the next level.

A checkout takes constant time. Each segment owns a one-bit generation value. A line holds a copy of that value from the moment it was filled. The line counts as valid only while its copy still matches the current generation of its segment. Flipping one segment's generation therefore invalidates all of its lines together. At the same flip, lines of that segment that were already stale are scrubbed, so a later flip back cannot revive them.

A checkin does not step through the whole array. It looks only at the lines that are valid, dirty and belong to the named segment, picks the lowest index among them, and issues a write-back request for it. It repeats this until no such line is left.

The cache reports fills and stores on an update port. A lookup port returns, one cycle later, whether a line is valid and whether it is dirty.

Top module: `segment_meta_tracker`

## Requirements
- R1: A synchronous reset makes every line invalid and clean, raises cmd_ready, and clears wb_valid and cmd_done.
- R2: A fill (upd_kind = 0) of a line makes it valid and clean, owned by upd_seg.
- R3: A store (upd_kind = 1) to a valid line sets its dirty bit; a store to an invalid line has no effect.
- R4: lk_valid and lk_dirty are registered. They show the state of line lk_idx as left by all earlier clock edges, and lk_dirty is 0 for an invalid line.
- R5: An accepted checkout (cmd_op = 0) invalidates every line of cmd_seg and no other line, pulses cmd_done in the next cycle, and keeps cmd_ready high.
- R6: A line refilled after a checkout of its segment is valid again and clean.
- R7: An accepted checkin (cmd_op = 1) issues one write-back on wb_idx for each valid dirty line of cmd_seg, in ascending index order, and none for lines of other segments.
- R8: wb_valid and wb_idx hold steady until wb_ready is seen. The line's dirty bit clears on that acceptance, and the line stays valid.
- R9: cmd_done pulses one cycle after the walk finds no remaining dirty line. A checkin with nothing to write back completes with cmd_done two cycles after acceptance.
- R10: While a checkin walk is in progress, cmd_ready is low and any offered command has no effect.
- R11: Refilling a line for a different segment moves it to that segment. It then ignores checkouts and checkins of its former segment.
- R12: A checkout discards dirty state: a dirty line of the checked-out segment produces no later write-back.
- R13: Two successive checkouts of a segment leave lines filled before the first one invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Update from the cache this cycle |
| upd_kind | input | 1 | 0 fill, 1 store |
| upd_idx | input | 6 | Line index of the update |
| upd_seg | input | 2 | Owning segment for a fill |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 1 | 0 checkout, 1 checkin |
| cmd_seg | input | 2 | Target segment of the command |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_done | output | 1 | One-cycle completion pulse |
| lk_idx | input | 6 | Line to look up |
| lk_valid | output | 1 | Looked-up line is valid |
| lk_dirty | output | 1 | Looked-up line is valid and dirty |
| wb_valid | output | 1 | Write-back request present |
| wb_idx | output | 6 | Line index to write back |
| wb_ready | input | 1 | Write-back request accepted |

## Verification
The assertions watch the handshakes on every cycle. They check that a pending write-back holds its index until accepted, that no command is taken while requests are still being issued, that a checkout completes in the following cycle, and that completion never coincides with a pending request. Only the bench scenarios can show which lines are affected. These include the segment isolation of a checkout, the scrubbing of stale lines across repeated checkouts, the ascending order and exact set of write-backs, the clearing of dirty bits, and the move of a line into a new segment. The bench confirms each of these through lookups and the write-back stream.

// File: rtl/smt_pkg.sv
package smt_pkg;
  typedef enum logic {OP_CHECKOUT = 1'b0, OP_CHECKIN = 1'b1} cmd_op_e;
  typedef enum logic {UPD_FILL = 1'b0, UPD_STORE = 1'b1} upd_kind_e;
  typedef enum logic {ENG_IDLE = 1'b0, ENG_WALK = 1'b1} eng_state_e;
endpackage

// File: rtl/smt_gen_bank.sv
// One generation bit per segment; a flip invalidates the segment at once.
module smt_gen_bank #(
  parameter int NUM_SEGS = 4,
  localparam int SEG_W = $clog2(NUM_SEGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flip_en,
  input  logic [SEG_W-1:0]    flip_seg,
  output logic [NUM_SEGS-1:0] gen_o
);
  for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
    logic gen_q;
    always_ff @(posedge clk) begin
      if (rst) gen_q <= 1'b0;
      else if (flip_en && flip_seg == SEG_W'(s)) gen_q <= ~gen_q;
    end
    assign gen_o[s] = gen_q;
  end
endmodule

// File: rtl/smt_line_meta.sv
// Per-line metastate: filled flag, generation copy, owner segment, dirty bit.
module smt_line_meta #(
  parameter int NUM_LINES = 64,
  parameter int NUM_SEGS  = 4,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int SEG_W = $clog2(NUM_SEGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SEGS-1:0]        gen_i,
  input  logic                       co_en,
  input  logic [SEG_W-1:0]           co_seg,
  input  logic                       fill_en,
  input  logic                       store_en,
  input  logic [IDX_W-1:0]           upd_idx,
  input  logic [SEG_W-1:0]           upd_seg,
  input  logic                       clr_en,
  input  logic [IDX_W-1:0]           clr_idx,
  output logic [NUM_LINES-1:0]       line_valid_o,
  output logic [NUM_LINES-1:0]       line_dirty_o,
  output logic [NUM_LINES*SEG_W-1:0] line_seg_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic             filled_q;
    logic             vtag_q;
    logic             dirty_q;
    logic [SEG_W-1:0] seg_q;
    logic             match;
    logic             hit_upd;

    // Valid when the stored copy XOR the segment generation is zero.
    assign match   = ~(vtag_q ^ gen_i[seg_q]);
    assign hit_upd = (upd_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        filled_q <= 1'b0;
        vtag_q   <= 1'b0;
        dirty_q  <= 1'b0;
        seg_q    <= '0;
      end else if (fill_en && hit_upd) begin
        filled_q <= 1'b1;
        vtag_q   <= gen_i[upd_seg];
        seg_q    <= upd_seg;
        dirty_q  <= 1'b0;
      end else begin
        // Already-stale lines of the flipped segment are scrubbed so the
        // next flip cannot bring them back.
        if (co_en && seg_q == co_seg && !match) begin
          filled_q <= 1'b0;
          dirty_q  <= 1'b0;
        end else begin
          if (clr_en && clr_idx == IDX_W'(i)) dirty_q <= 1'b0;
          if (store_en && hit_upd && filled_q && match) dirty_q <= 1'b1;
        end
      end
    end

    assign line_valid_o[i] = filled_q & match;
    assign line_dirty_o[i] = dirty_q;
    assign line_seg_o[i*SEG_W +: SEG_W] = seg_q;
  end
endmodule

// File: rtl/smt_pick_first.sv
// Lowest-index set bit of a request vector.
module smt_pick_first #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/segment_meta_tracker.sv
module segment_meta_tracker
  import smt_pkg::*;
#(
  parameter int NUM_SEGS  = 4,
  parameter int NUM_LINES = 64,
  localparam int SEG_W = $clog2(NUM_SEGS),
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic             upd_kind,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [SEG_W-1:0] upd_seg,
  input  logic             cmd_valid,
  input  logic             cmd_op,
  input  logic [SEG_W-1:0] cmd_seg,
  output logic             cmd_ready,
  output logic             cmd_done,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic             lk_dirty,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  input  logic             wb_ready
);
  eng_state_e             state_q;
  logic [SEG_W-1:0]       cur_seg_q;
  logic [NUM_SEGS-1:0]    gen;
  logic [NUM_LINES-1:0]   line_valid;
  logic [NUM_LINES-1:0]   line_dirty;
  logic [NUM_LINES*SEG_W-1:0] line_seg;
  logic [NUM_LINES-1:0]   cand;
  logic                   pick_any;
  logic [IDX_W-1:0]       pick_idx;
  logic                   accept, co_fire, ci_fire, wb_take;

  assign cmd_ready = (state_q == ENG_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign co_fire   = accept && (cmd_op == OP_CHECKOUT);
  assign ci_fire   = accept && (cmd_op == OP_CHECKIN);
  assign wb_take   = wb_valid && wb_ready;

  smt_gen_bank #(.NUM_SEGS(NUM_SEGS)) u_gen (
    .clk(clk), .rst(rst), .flip_en(co_fire), .flip_seg(cmd_seg), .gen_o(gen)
  );

  smt_line_meta #(.NUM_LINES(NUM_LINES), .NUM_SEGS(NUM_SEGS)) u_meta (
    .clk(clk), .rst(rst), .gen_i(gen),
    .co_en(co_fire), .co_seg(cmd_seg),
    .fill_en(upd_en && upd_kind == UPD_FILL),
    .store_en(upd_en && upd_kind == UPD_STORE),
    .upd_idx(upd_idx), .upd_seg(upd_seg),
    .clr_en(wb_take), .clr_idx(wb_idx),
    .line_valid_o(line_valid), .line_dirty_o(line_dirty), .line_seg_o(line_seg)
  );

  // Candidates: valid, dirty lines of the segment being checked in.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_cand
    assign cand[i] = line_valid[i] & line_dirty[i] &
                     (line_seg[i*SEG_W +: SEG_W] == cur_seg_q);
  end

  smt_pick_first #(.N(NUM_LINES)) u_pick (
    .req(cand), .any(pick_any), .idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ENG_IDLE;
      cur_seg_q <= '0;
      wb_valid  <= 1'b0;
      wb_idx    <= '0;
      cmd_done  <= 1'b0;
      lk_valid  <= 1'b0;
      lk_dirty  <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      lk_valid <= line_valid[lk_idx];
      lk_dirty <= line_valid[lk_idx] & line_dirty[lk_idx];
      case (state_q)
        ENG_IDLE: begin
          if (co_fire) begin
            cmd_done <= 1'b1;
          end else if (ci_fire) begin
            state_q   <= ENG_WALK;
            cur_seg_q <= cmd_seg;
          end
        end
        ENG_WALK: begin
          if (wb_valid) begin
            if (wb_ready) wb_valid <= 1'b0;
          end else if (pick_any) begin
            wb_valid <= 1'b1;
            wb_idx   <= pick_idx;
          end else begin
            state_q  <= ENG_IDLE;
            cmd_done <= 1'b1;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smt_checker.sv
module smt_checker #(
  parameter int NUM_SEGS  = 4,
  parameter int NUM_LINES = 64,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_op,
  input logic             cmd_ready,
  input logic             cmd_done,
  input logic             wb_valid,
  input logic [IDX_W-1:0] wb_idx,
  input logic             wb_ready
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (cmd_ready && !wb_valid && !cmd_done));

  assert_checkout_done_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && !cmd_op) |=> (cmd_done && cmd_ready));

  assert_wb_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_idx)));

  assert_done_after_wb_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> !wb_valid);

  assert_walk_busy_R10: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> !cmd_ready);

  assert_checkin_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op) |=> (!cmd_ready && !cmd_done));
endmodule

bind segment_meta_tracker smt_checker #(
  .NUM_SEGS(NUM_SEGS), .NUM_LINES(NUM_LINES)
) u_chk (.*);

// File: tb/sim_segment_meta_tracker.sv
`timescale 1ns/1ps
module sim_segment_meta_tracker;
  logic clk = 1'b0, rst = 1'b1;
  logic upd_en = 0, upd_kind = 0, cmd_valid = 0, cmd_op = 0, wb_ready = 1;
  logic [5:0] upd_idx = 0, lk_idx = 0, wb_idx;
  logic [1:0] upd_seg = 0, cmd_seg = 0;
  logic cmd_ready, cmd_done, lk_valid, lk_dirty, wb_valid;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  segment_meta_tracker u0 (.*);

  // kind: 0 fill, 1 store, 2 lookup, 3 checkout
  function automatic logic [15:0] mk(int k, int i, int s, int r, int v, int d);
    return {2'(k), 6'(i), 2'(s), 4'(r), 1'(v), 1'(d)};
  endfunction

  localparam int NV = 26;
  localparam logic [15:0] VEC [NV] = '{
    mk(2, 5,0, 1,0,0),  // R1 lines start invalid
    mk(0, 5,1, 2,0,0),
    mk(2, 5,0, 2,1,0),  // R2 fill gives valid clean
    mk(1, 5,0, 3,0,0),
    mk(2, 5,0, 3,1,1),  // R3 store sets dirty
    mk(1, 9,0, 3,0,0),
    mk(2, 9,0, 3,0,0),  // R3 store to invalid line ignored
    mk(0, 9,2, 2,0,0),
    mk(1, 9,0, 3,0,0),
    mk(2, 9,0, 4,1,1),  // R4 lookup reflects prior edges
    mk(0,20,1, 2,0,0),
    mk(1,20,0, 3,0,0),
    mk(0,40,1, 2,0,0),
    mk(3, 0,2, 5,0,0),
    mk(2, 9,0,12,0,0),  // R12 dirty line dropped by checkout
    mk(2, 5,0, 5,1,1),  // R5 other segment untouched
    mk(0, 9,2, 6,0,0),
    mk(2, 9,0, 6,1,0),  // R6 refill after checkout
    mk(3, 0,2, 5,0,0),
    mk(3, 0,2, 5,0,0),
    mk(2, 9,0,13,0,0),  // R13 double checkout keeps line invalid
    mk(0,63,1, 2,0,0),
    mk(1,63,0, 3,0,0),
    mk(0, 0,3, 2,0,0),
    mk(1, 0,0, 3,0,0),
    mk(2,40,0, 4,1,0)
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic upd(input int kind, input int idx, input int seg);
    upd_en = 1; upd_kind = 1'(kind); upd_idx = 6'(idx); upd_seg = 2'(seg);
    step();
    upd_en = 0;
  endtask

  task automatic look(input int idx, input int ev, input int ed, input string req);
    lk_idx = 6'(idx);
    step();
    chk(lk_valid == 1'(ev), req, lk_valid, ev);
    chk(lk_dirty == 1'(ed), req, lk_dirty, ed);
  endtask

  task automatic checkout(input int seg);
    cmd_valid = 1; cmd_op = 0; cmd_seg = 2'(seg);
    step();
    cmd_valid = 0;
    chk(cmd_done == 1'b1, "R5 done", cmd_done, 1);
    chk(cmd_ready == 1'b1, "R5 ready", cmd_ready, 1);
  endtask

  task automatic checkin(input int seg, input int n_exp, input int e0, input int e1,
                         input int e2, input bit stall, output int cyc);
    int exp_list [3];
    int got = 0, held = 0;
    logic [5:0] hold_idx = 0;
    exp_list[0] = e0; exp_list[1] = e1; exp_list[2] = e2;
    cmd_valid = 1; cmd_op = 1; cmd_seg = 2'(seg);
    step();
    cmd_valid = 0;
    chk(cmd_ready == 1'b0, "R10 busy after checkin", cmd_ready, 0);
    wb_ready = !stall;
    cyc = 0;
    while (!cmd_done && cyc < 200) begin
      if (wb_valid) begin
        if (stall && held < 3) begin
          if (held == 0) hold_idx = wb_idx;
          else chk(wb_idx == hold_idx, "R8 idx held", wb_idx, hold_idx);
          held++;
          wb_ready = 0;
          cmd_valid = 1; cmd_op = 0; cmd_seg = 2'd3;
          chk(cmd_ready == 1'b0, "R10 no accept", cmd_ready, 0);
        end else begin
          wb_ready = 1; cmd_valid = 0;
          if (got < 3) chk(int'(wb_idx) == exp_list[got], "R7 wb order", wb_idx, exp_list[got]);
          got++;
        end
      end
      step();
      cyc++;
    end
    cmd_valid = 0; wb_ready = 1;
    chk(got == n_exp, "R7 wb count", got, n_exp);
    chk(cmd_done == 1'b1, "R9 done", cmd_done, 1);
    chk(cmd_ready == 1'b1, "R9 ready again", cmd_ready, 1);
  endtask

  initial begin
    int cyc;
    repeat (3) step();
    rst = 0;
    step();
    chk(cmd_ready && !wb_valid && !cmd_done, "R1 idle outputs", cmd_ready, 1);

    for (int r = 0; r < NV; r++) begin
      int k, i, s, q;
      k = int'(VEC[r][15:14]); i = int'(VEC[r][13:8]);
      s = int'(VEC[r][7:6]);   q = int'(VEC[r][5:2]);
      case (k)
        0: upd(0, i, s);
        1: upd(1, i, s);
        2: look(i, VEC[r][1], VEC[r][0], $sformatf("R%0d row %0d", q, r));
        default: checkout(s);
      endcase
    end

    // R7 R8 R10: checkin of segment 1 with a stalled first request
    checkin(1, 3, 5, 20, 63, 1'b1, cyc);
    look(5, 1, 0, "R8 dirty cleared");
    look(63, 1, 0, "R8 dirty cleared");
    look(0, 1, 1, "R10 blocked checkout had no effect");

    // R9: nothing left to write
    checkin(1, 0, 0, 0, 0, 1'b0, cyc);
    chk(cyc == 1, "R9 empty checkin latency", cyc, 1);

    // R11: line 20 moves to segment 3
    upd(0, 20, 3);
    upd(1, 20, 0);
    checkout(1);
    look(20, 1, 1, "R11 former segment checkout ignored");
    look(5, 0, 0, "R5 segment lines invalid");
    checkin(3, 2, 0, 20, 0, 1'b0, cyc);

    // R1: reset mid-run
    rst = 1;
    step(); step();
    rst = 0;
    look(0, 0, 0, "R1 reset clears lines");
    chk(cmd_ready && !wb_valid && !cmd_done, "R1 idle after reset", cmd_ready, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule